// File: doc/BRIEF.md
# Shared Issue-Queue Entry Admission Controller

This block keeps the entry accounting for an issue queue that several hardware threads share. It records how many entries each thread holds and decides in the same cycle whether a thread's dispatch request may take another entry. It also publishes per-thread and global free counts and full flags, which the dispatch stage uses to throttle itself. The block stores no instruction payloads and does not select instructions for issue.

Each thread's entry ceiling comes from one of three sharing policies, picked by a configuration input. Under the shared policy every thread may use the whole queue. Under the split policy the queue is divided evenly among the currently active threads. Under the capped policy every thread gets a configured percentage of the queue, except that a lone active thread gets the whole queue. The ceilings sit in registers and follow the policy, percentage and active-thread mask one cycle after those inputs change.

Entries return through per-thread single-entry release strobes and through one squash port that returns a count of entries for one thread. Requests that cannot be honoured are refused and reported on per-thread error flags. There is no data stream at the block edge: allocation is a request/grant pair that the block decides in the same cycle, and all other pins are plain control and status.

Top module: `smtq_alloc_ctrl`

## Requirements
- R1: With `pol_sel` = 0 (shared) or 3 (treated as shared), every thread's ceiling is NUM_ENTRIES.
- R2: With `pol_sel` = 1 (split), every thread's ceiling is NUM_ENTRIES divided by the number of set bits in `active_mask`, rounded down, or NUM_ENTRIES/NUM_THREADS when the mask is zero. The new value applies from the clock edge after the mask changes.
- R3: With `pol_sel` = 2 (capped), every thread's ceiling is floor(NUM_ENTRIES*min(`thresh_pct`,100)/100). When exactly one bit of `active_mask` is set, that thread's ceiling is NUM_ENTRIES instead.
- R4: Field t of `thr_free` (bits t*CW to t*CW+CW-1) equals the thread's ceiling minus its occupancy, saturated at zero. `thr_full[t]` is 1 exactly when that field is zero.
- R5: `alloc_grant[t]` is raised in the cycle of `alloc_req[t]` only if thread t is not full and global room remains. Among simultaneous requests, lower thread indices are served first until the global free count is used up.
- R6: `glob_free` equals NUM_ENTRIES minus the sum of all occupancies. It falls by one per grant and rises by one per entry returned, and `glob_full` is 1 exactly when it is zero.
- R7: A refused request sets `err_alloc[t]` on the following cycle, with no change to any count.
- R8: `release_req[t]` returns one entry of thread t. When `sq_valid` is set, the squash port returns `sq_count` entries of thread `sq_tid`. A combined return larger than the thread's occupancy empties the thread, which also covers a release on an empty thread that is ignored, and sets `err_release[t]` on the following cycle.
- R9: Reset empties every thread, sets `glob_free` to NUM_ENTRIES and clears both error vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 2 | Sharing policy: 0 shared, 1 split, 2 capped, 3 shared |
| thresh_pct | input | PCT_W | Per-thread percentage for the capped policy |
| active_mask | input | NUM_THREADS | One bit per running thread |
| alloc_req | input | NUM_THREADS | Per-thread request for one entry |
| release_req | input | NUM_THREADS | Per-thread return of one entry |
| sq_valid | input | 1 | Squash return valid |
| sq_tid | input | TW | Thread whose entries the squash returns |
| sq_count | input | CW | Number of entries the squash returns |
| alloc_grant | output | NUM_THREADS | Same-cycle acceptance of each request |
| thr_free | output | NUM_THREADS*CW | Per-thread free counts, thread t in field t |
| thr_full | output | NUM_THREADS | Per-thread full flags |
| glob_free | output | CW | Free entries across the queue |
| glob_full | output | 1 | Queue has no free entry |
| err_alloc | output | NUM_THREADS | Refused request seen last cycle |
| err_release | output | NUM_THREADS | Over-return seen last cycle |

## Verification
Allocation and return can hit the same thread in one cycle, and a ceiling change can land while a thread holds more entries than its new ceiling. The bench provokes the first by driving grants alongside single releases and squash counts on the same thread, including returns that exceed occupancy. It provokes the second by narrowing the active mask or the percentage while threads are loaded. A bench model of occupancies, global room and registered ceilings predicts every grant, free count and error bit for each cycle. The random phase hits these collisions thousands of times, and directed steps pin the priority order when only one or two global entries remain.

// File: rtl/smtq_pkg.sv
package smtq_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_CAP    = 2'd2,
    POL_RSVD   = 2'd3
  } alloc_policy_e;
endpackage

// File: rtl/smtq_limit_calc.sv
module smtq_limit_calc
  import smtq_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 32,
  parameter int PCT_W       = 7,
  parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                pol_sel,
  input  logic [PCT_W-1:0]          thresh_pct,
  input  logic [NUM_THREADS-1:0]    active_mask,
  output logic [NUM_THREADS*CW-1:0] limit_q
);
  localparam int NW = $clog2(NUM_THREADS + 1);
  localparam int PW = CW + PCT_W;

  alloc_policy_e    pol;
  logic [NW-1:0]    n_act;
  logic [CW-1:0]    split_lim;
  logic [PCT_W-1:0] pct_c;
  logic [PW-1:0]    prod;
  logic [CW-1:0]    cap_lim;

  assign pol = alloc_policy_e'(pol_sel);

  always_comb begin
    n_act = '0;
    for (int t = 0; t < NUM_THREADS; t++) n_act = n_act + NW'(active_mask[t]);
  end

  // Divisor is small, so each quotient is a constant picked by the count.
  always_comb begin
    split_lim = CW'(NUM_ENTRIES / NUM_THREADS);
    for (int k = 1; k <= NUM_THREADS; k++)
      if (n_act == NW'(k)) split_lim = CW'(NUM_ENTRIES / k);
  end

  assign pct_c   = (thresh_pct > PCT_W'(100)) ? PCT_W'(100) : thresh_pct;
  assign prod    = PW'(NUM_ENTRIES) * PW'(pct_c);
  assign cap_lim = CW'(prod / PW'(100));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CW-1:0] lim_d;
    logic [CW-1:0] lim_r;

    always_comb begin
      unique case (pol)
        POL_SPLIT: lim_d = split_lim;
        POL_CAP:   lim_d = (n_act == NW'(1) && active_mask[t]) ? CW'(NUM_ENTRIES) : cap_lim;
        default:   lim_d = CW'(NUM_ENTRIES);
      endcase
    end

    // Ceilings load every cycle, including during reset.
    always_ff @(posedge clk) lim_r <= lim_d;

    assign limit_q[t*CW +: CW] = lim_r;

    AST_LIMIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      lim_r <= CW'(NUM_ENTRIES)); // R3
    AST_SHARED_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_sel == 2'd0) |=> (lim_r == CW'(NUM_ENTRIES))); // R1
  end
endmodule

// File: rtl/smtq_thread_slot.sv
module smtq_thread_slot #(
  parameter int NUM_ENTRIES = 32,
  parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  input  logic          grant,
  input  logic          rel,
  input  logic          sq_hit,
  input  logic [CW-1:0] sq_count,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] free,
  output logic          full,
  output logic [CW-1:0] returned,
  output logic          err_rel_q
);
  logic [CW-1:0] occ_q;
  logic [CW:0]   dec_want;
  logic          over;

  assign dec_want = (CW+1)'(rel) + (sq_hit ? {1'b0, sq_count} : '0);
  assign over     = dec_want > {1'b0, occ_q};
  assign returned = over ? occ_q : dec_want[CW-1:0];

  assign free = (occ_q >= limit) ? '0 : limit - occ_q;
  assign full = (free == '0);
  assign occ  = occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q     <= '0;
      err_rel_q <= 1'b0;
    end else begin
      occ_q     <= occ_q - returned + CW'(grant);
      err_rel_q <= over;
    end
  end

  AST_GRANT_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !full); // R5
  AST_EMPTY_RELEASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && occ_q == '0) |=> err_rel_q); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(NUM_ENTRIES)); // R4
endmodule

// File: rtl/smtq_admit_arb.sv
module smtq_admit_arb #(
  parameter int NUM_THREADS = 4,
  parameter int CW          = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] req,
  input  logic [NUM_THREADS-1:0] thr_full,
  input  logic [CW-1:0]          glob_free,
  output logic [NUM_THREADS-1:0] grant,
  output logic [NUM_THREADS-1:0] err_q
);
  logic [CW-1:0] used;

  // Lowest index first; stop once the global room is spent.
  always_comb begin
    used  = '0;
    grant = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (req[t] && !thr_full[t] && (used < glob_free)) begin
        grant[t] = 1'b1;
        used     = used + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= req & ~grant;
  end

  AST_GRANT_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= int'(glob_free)); // R5
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0); // R5
  AST_REFUSAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req[0] && !grant[0]) |=> err_q[0]); // R7
endmodule

// File: rtl/smtq_alloc_ctrl.sv
module smtq_alloc_ctrl #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 32,
  parameter int PCT_W       = 7,
  parameter int CW          = $clog2(NUM_ENTRIES + 1),
  parameter int TW          = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                pol_sel,
  input  logic [PCT_W-1:0]          thresh_pct,
  input  logic [NUM_THREADS-1:0]    active_mask,
  input  logic [NUM_THREADS-1:0]    alloc_req,
  input  logic [NUM_THREADS-1:0]    release_req,
  input  logic                      sq_valid,
  input  logic [TW-1:0]             sq_tid,
  input  logic [CW-1:0]             sq_count,
  output logic [NUM_THREADS-1:0]    alloc_grant,
  output logic [NUM_THREADS*CW-1:0] thr_free,
  output logic [NUM_THREADS-1:0]    thr_full,
  output logic [CW-1:0]             glob_free,
  output logic                      glob_full,
  output logic [NUM_THREADS-1:0]    err_alloc,
  output logic [NUM_THREADS-1:0]    err_release
);
  localparam int SW = CW + TW + 1;

  logic [NUM_THREADS*CW-1:0] limit_q;
  logic [NUM_THREADS*CW-1:0] occ_flat;
  logic [NUM_THREADS*CW-1:0] ret_flat;
  logic [CW-1:0]             glob_free_q;
  logic [SW-1:0]             ret_sum;
  logic [SW-1:0]             grant_sum;
  logic [SW-1:0]             occ_sum;

  smtq_limit_calc #(
    .NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .PCT_W(PCT_W), .CW(CW)
  ) u_limit (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .thresh_pct(thresh_pct),
    .active_mask(active_mask), .limit_q(limit_q)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
    smtq_thread_slot #(.NUM_ENTRIES(NUM_ENTRIES), .CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .limit(limit_q[t*CW +: CW]),
      .grant(alloc_grant[t]),
      .rel(release_req[t]),
      .sq_hit(sq_valid && (sq_tid == TW'(t))),
      .sq_count(sq_count),
      .occ(occ_flat[t*CW +: CW]),
      .free(thr_free[t*CW +: CW]),
      .full(thr_full[t]),
      .returned(ret_flat[t*CW +: CW]),
      .err_rel_q(err_release[t])
    );
  end

  smtq_admit_arb #(.NUM_THREADS(NUM_THREADS), .CW(CW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(alloc_req), .thr_full(thr_full),
    .glob_free(glob_free_q), .grant(alloc_grant), .err_q(err_alloc)
  );

  always_comb begin
    ret_sum   = '0;
    grant_sum = '0;
    occ_sum   = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      ret_sum   = ret_sum + SW'(ret_flat[t*CW +: CW]);
      grant_sum = grant_sum + SW'(alloc_grant[t]);
      occ_sum   = occ_sum + SW'(occ_flat[t*CW +: CW]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) glob_free_q <= CW'(NUM_ENTRIES);
    else        glob_free_q <= CW'(SW'(glob_free_q) + ret_sum - grant_sum);
  end

  assign glob_free = glob_free_q;
  assign glob_full = (glob_free_q == '0);

  AST_GLOBAL_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (SW'(glob_free_q) + occ_sum) == SW'(NUM_ENTRIES)); // R6
  AST_FULL_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    glob_full |-> (alloc_grant == '0)); // R6
endmodule

// File: tb/smtq_alloc_ctrl_bench.sv
module smtq_alloc_ctrl_bench;
  localparam int T  = 4;
  localparam int N  = 32;
  localparam int CW = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   pol_sel;
  logic [6:0]   thresh_pct;
  logic [T-1:0] active_mask, alloc_req, release_req;
  logic         sq_valid;
  logic [1:0]   sq_tid;
  logic [CW-1:0] sq_count;
  logic [T-1:0] alloc_grant, thr_full, err_alloc, err_release;
  logic [T*CW-1:0] thr_free;
  logic [CW-1:0] glob_free;
  logic          glob_full;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int occ_m[T], lim_m[T], glob_m;

  always #10 clk = ~clk; // 50 MHz

  smtq_alloc_ctrl u_smtq_alloc_ctrl (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .thresh_pct(thresh_pct),
    .active_mask(active_mask), .alloc_req(alloc_req), .release_req(release_req),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_count(sq_count),
    .alloc_grant(alloc_grant), .thr_free(thr_free), .thr_full(thr_full),
    .glob_free(glob_free), .glob_full(glob_full),
    .err_alloc(err_alloc), .err_release(err_release)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int calc_lim(int t, int pol, int mask, int pct);
    int n = 0;
    for (int i = 0; i < T; i++) n += mask[i];
    if (pol == 1) return (n == 0) ? N / T : N / n;
    if (pol == 2) begin
      if (n == 1 && mask[t]) return N;
      return N * ((pct > 100) ? 100 : pct) / 100;
    end
    return N;
  endfunction

  function automatic int free_m(int t);
    return (occ_m[t] >= lim_m[t]) ? 0 : lim_m[t] - occ_m[t];
  endfunction

  // Called at a negedge; drives, checks before the edge, then checks flags.
  task automatic step(logic [T-1:0] a, logic [T-1:0] r, logic sv, int st, int sc);
    int budget, dw, da;
    logic [T-1:0] eg, ea, er;
    int occ_n[T], glob_n;
    alloc_req = a; release_req = r; sq_valid = sv;
    sq_tid = st[1:0]; sq_count = sc[CW-1:0];
    #1;
    budget = glob_m;
    glob_n = glob_m;
    for (int t = 0; t < T; t++) begin
      chk("R4 thr_free", int'(thr_free[t*CW +: CW]), free_m(t));
      chk("R4 thr_full", int'(thr_full[t]), int'(free_m(t) == 0));
      eg[t] = a[t] && free_m(t) > 0 && budget > 0;
      if (eg[t]) budget--;
    end
    chk("R5 alloc_grant", int'(alloc_grant), int'(eg));
    chk("R6 glob_free", int'(glob_free), glob_m);
    chk("R6 glob_full", int'(glob_full), int'(glob_m == 0));
    for (int t = 0; t < T; t++) begin
      dw = int'(r[t]) + ((sv && st == t) ? sc : 0);
      er[t] = dw > occ_m[t];
      da = er[t] ? occ_m[t] : dw;
      ea[t] = a[t] && !eg[t];
      occ_n[t] = occ_m[t] - da + int'(eg[t]);
      glob_n = glob_n + da - int'(eg[t]);
    end
    @(posedge clk);
    for (int t = 0; t < T; t++) begin
      occ_m[t] = occ_n[t];
      lim_m[t] = calc_lim(t, pol_sel, active_mask, thresh_pct);
    end
    glob_m = glob_n;
    @(negedge clk);
    chk("R7 err_alloc", int'(err_alloc), int'(ea));
    chk("R8 err_release", int'(err_release), int'(er));
  endtask

  task automatic idle();
    step('0, '0, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; pol_sel = 2'd0; thresh_pct = 7'd50; active_mask = 4'hF;
    alloc_req = '0; release_req = '0; sq_valid = 0; sq_tid = '0; sq_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int t = 0; t < T; t++) begin occ_m[t] = 0; lim_m[t] = N; end
    glob_m = N;
    #1;
    // R9 reset state
    chk("R9 glob_free", int'(glob_free), N);
    chk("R9 err_alloc", int'(err_alloc), 0);
    chk("R9 err_release", int'(err_release), 0);
    chk("R9 thr_free0", int'(thr_free[0 +: CW]), N);
    @(negedge clk);

    // R1: one thread fills the whole queue under shared policy
    for (int i = 0; i < N + 2; i++) step(4'b0001, '0, 0, 0, 0);
    chk("R1 thr_free0 after fill", int'(thr_free[0 +: CW]), 0);
    chk("R6 glob_full after fill", int'(glob_full), 1);

    // R5: two entries back, three requesters; threads 1 and 2 win
    step('0, 4'b0001, 0, 0, 0);
    step('0, 4'b0001, 0, 0, 0);
    step(4'b1110, '0, 0, 0, 0);
    chk("R5 thread3 refused flag", int'(err_alloc[3]), 1);

    // R8: squash beyond occupancy, then release on empty thread
    step('0, '0, 1, 0, 40);
    step('0, 4'b0001, 0, 0, 0);
    chk("R8 empty release flagged", int'(err_release[0]), 1);
    // R8: allocate and squash the same thread in one cycle
    step(4'b0010, '0, 1, 1, 1);

    // R2: split policy follows the active mask
    pol_sel = 2'd1; active_mask = 4'b0011; idle(); idle();
    chk("R2 split by two", int'(thr_free[2*CW +: CW]), 16 - occ_m[2]);
    active_mask = 4'b0000; idle(); idle();
    chk("R2 zero mask", int'(thr_free[3*CW +: CW]), 8);

    // R3: capped policy, single-thread boost and clamp
    pol_sel = 2'd2; thresh_pct = 7'd50; active_mask = 4'b0110; idle(); idle();
    chk("R3 half cap", int'(thr_free[3*CW +: CW]), 16);
    active_mask = 4'b0100; idle(); idle();
    chk("R3 lone thread boost", int'(thr_free[2*CW +: CW]), 32 - occ_m[2]);
    active_mask = 4'b1111; thresh_pct = 7'd120; idle(); idle();
    chk("R3 percent clamp", int'(thr_free[3*CW +: CW]), 32);
    thresh_pct = 7'd10; idle(); idle();
    chk("R3 ten percent", int'(thr_free[3*CW +: CW]), 3);

    // R1: encoding 3 behaves as shared
    pol_sel = 2'd3; idle(); idle();
    chk("R1 reserved encoding", int'(thr_free[3*CW +: CW]), 32);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [T-1:0] a, r;
      if (i % 61 == 0) begin
        pol_sel = 2'($urandom_range(0, 3));
        active_mask = 4'($urandom);
        thresh_pct = 7'($urandom_range(0, 127));
      end
      for (int t = 0; t < T; t++) begin
        a[t] = ($urandom_range(0, 99) < 55);
        r[t] = ($urandom_range(0, 99) < 30);
      end
      step(a, r, ($urandom_range(0, 99) < 8), $urandom_range(0, 3), $urandom_range(0, 9));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule